// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a 7-bit digital step attenuator and writes one attenuation code into it over a three-wire serial link. The three lines are data, shift clock and latch. A one-cycle start request loads a code. The block then shifts the code out most significant bit first. The attenuator captures each bit on a rising shift clock. After the last bit the block raises the latch line in a separate pulse, and the new code takes effect in the attenuator. The mode-select line is held high the whole time, so the attenuator stays in serial mode.

Every interface time is a parameter counted in system-clock cycles, each rounded up from the nanosecond minimum. These times are the clock low and high phases, the latch setup, the latch width and the gap after the latch. The sequence is fixed, so the latency from start to done is the same for every code. The block holds `busy_o` high from the cycle after acceptance until the minimum latch-to-latch spacing has passed. A start request that arrives while busy has no effect.

Top module: `atten_ser_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o`, `done_o`, `ser_clk_o`, `ser_le_o` and `ser_data_o` are all 0.
- R2: `ser_mode_o` is 1 in every cycle, which selects serial mode.
- R3: After a start is accepted, each of the WORD_W bits takes LO_CYC cycles with `ser_clk_o` low followed by HI_CYC cycles with it high. Bit k of the transfer (k = 0 first) carries code bit WORD_W-1-k, so the MSB goes first.
- R4: `ser_data_o` changes only in a cycle where `ser_clk_o` is low. It is stable for at least 15 ns before every rising shift clock and for at least 20 ns after it. The shift-clock period is at least 70 ns.
- R5: After the last falling shift clock, `ser_le_o` stays low for LE_SETUP_CYC cycles and is then high for LE_HIGH_CYC cycles. `ser_clk_o` is low in every cycle where `ser_le_o` is high. Successive rising latch edges are at least 630 ns apart.
- R6: `done_o` is a single-cycle pulse exactly WORD_W*(LO_CYC+HI_CYC)+LE_SETUP_CYC+LE_HIGH_CYC cycles after the accepting edge. The word the attenuator has latched by then equals the requested code.
- R7: `busy_o` is 1 from the accepting edge until LE_GAP_CYC cycles after `done_o`. A start with `busy_o` low is accepted at the next clock edge.
- R8: A start request while `busy_o` is 1 is ignored: the transfer in flight and its latched word are unchanged.
- R9: When idle, `ser_clk_o`, `ser_le_o` and `ser_data_o` are 0, and `ser_le_o` is 0 throughout the shift phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to write `code_i` |
| code_i | input | WORD_W | Attenuation code to send |
| busy_o | output | 1 | Transfer or latch spacing in progress |
| done_o | output | 1 | One-cycle pulse when the word has been latched |
| ser_data_o | output | 1 | Serial data to attenuator |
| ser_clk_o | output | 1 | Serial shift clock |
| ser_le_o | output | 1 | Latch enable |
| ser_mode_o | output | 1 | Serial/parallel select, held high |

## Verification
A behavioural slave timestamps every edge and checks data setup and hold, clock period, latch setup, latch width and latch spacing. A design that moved data on the rising clock, or raised the latch while the clock was high, would trip one of these checks. The codes 0x00, 0x7F, 0x55, 0x2A, 0x01 and 0x40 expose bit-order reversal and stuck or skipped bits. A start pulsed mid-transfer with the inverted code would corrupt the latched word if the block did not ignore it. A start held high across back-to-back writes shows whether the gap is enforced: releasing busy early would shorten the latch spacing and shift every expected edge of the per-cycle model.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_LE_SETUP,
    ST_LE_HIGH,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/atten_shift_reg.sv
module atten_shift_reg #(
  parameter int WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sh_en;

  always_comb begin
    sh_en = load_i || shift_i;
    sh_d  = load_i ? word_i : {sh_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign msb_o = sh_q[WORD_W-1];
endmodule

// File: rtl/atten_ser_master.sv
module atten_ser_master
  import atten_ser_pkg::*;
#(
  parameter int WORD_W       = 7,
  parameter int LO_CYC       = 7,
  parameter int HI_CYC       = 7,
  parameter int LE_SETUP_CYC = 3,
  parameter int LE_HIGH_CYC  = 2,
  parameter int LE_GAP_CYC   = 126
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ser_data_o,
  output logic              ser_clk_o,
  output logic              ser_le_o,
  output logic              ser_mode_o
);
  localparam int MAX_A   = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int MAX_B   = (LE_SETUP_CYC > LE_HIGH_CYC) ? LE_SETUP_CYC : LE_HIGH_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > LE_GAP_CYC) ? MAX_C : LE_GAP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int IDX_W   = (WORD_W > 2) ? $clog2(WORD_W) : 1;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_msb;

  atten_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  atten_shift_reg #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (sh_load),
    .shift_i(sh_shift),
    .word_i (code_i),
    .msb_o  (sh_msb)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_BIT_LO;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(LO_CYC - 1);
          sh_load  = 1'b1;
          idx_d    = IDX_W'(WORD_W - 1);
        end
      end
      ST_BIT_LO: begin
        if (tmr_zero) begin
          state_d  = ST_BIT_HI;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HI_CYC - 1);
        end
      end
      ST_BIT_HI: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (idx_q == '0) begin
            state_d = ST_LE_SETUP;
            tmr_val = CNT_W'(LE_SETUP_CYC - 1);
          end else begin
            state_d  = ST_BIT_LO;
            tmr_val  = CNT_W'(LO_CYC - 1);
            sh_shift = 1'b1;
            idx_d    = idx_q - IDX_W'(1);
          end
        end
      end
      ST_LE_SETUP: begin
        if (tmr_zero) begin
          state_d  = ST_LE_HIGH;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(LE_HIGH_CYC - 1);
        end
      end
      ST_LE_HIGH: begin
        if (tmr_zero) begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(LE_GAP_CYC - 1);
          done_d   = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign ser_clk_o  = (state_q == ST_BIT_HI);
  assign ser_le_o   = (state_q == ST_LE_HIGH);
  assign ser_data_o = ((state_q == ST_BIT_LO) || (state_q == ST_BIT_HI)) && sh_msb;
  assign ser_mode_o = 1'b1;
endmodule

// File: rtl/atten_ser_master_chk.sv
module atten_ser_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic ser_data_o,
  input logic ser_clk_o,
  input logic ser_le_o
);
  a_r5_clk_low_with_le: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le_o |-> !ser_clk_o);

  a_r4_data_stable_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));

  a_r4_data_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk_o) |-> $stable(ser_data_o));

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_done_after_le: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_o && $fell(ser_le_o)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ser_clk_o && !ser_le_o && !ser_data_o));

  a_r5_le_rise_after_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_le_o) |-> (!$past(ser_clk_o) && busy_o));
endmodule

bind atten_ser_master atten_ser_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ser_data_o(ser_data_o),
  .ser_clk_o (ser_clk_o),
  .ser_le_o  (ser_le_o)
);

// File: tb/atten_ser_master_tb.sv
`timescale 1ns/1ps
module atten_ser_master_tb_top;
  localparam int WORD_W = 7;
  localparam int LO = 7, HI = 7, LES = 3, LEW = 2, GAP = 126;
  localparam int P      = LO + HI;
  localparam int DONE_T = WORD_W * P + LES + LEW;
  localparam int END_T  = DONE_T + GAP;

  logic clk, rst_n, start_i;
  logic [WORD_W-1:0] code_i;
  logic busy_o, done_o, ser_data_o, ser_clk_o, ser_le_o, ser_mode_o;

  int n_chk, n_fail, cyc;

  atten_ser_master #(.WORD_W(WORD_W), .LO_CYC(LO), .HI_CYC(HI), .LE_SETUP_CYC(LES),
                     .LE_HIGH_CYC(LEW), .LE_GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_i(code_i),
    .busy_o(busy_o), .done_o(done_o), .ser_data_o(ser_data_o),
    .ser_clk_o(ser_clk_o), .ser_le_o(ser_le_o), .ser_mode_o(ser_mode_o));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // behavioural reference model: time since acceptance
  bit m_act;
  int m_t;
  logic [WORD_W-1:0] m_code;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0;
    end else if (m_act) begin
      m_t++;
      if (m_t == END_T) m_act = 0;
    end else if (start_i) begin
      m_act = 1; m_t = 0; m_code = code_i;
    end
  end

  bit cmp_en;
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      bit e_clk, e_le, e_data, e_done;
      e_clk = 0; e_le = 0; e_data = 0; e_done = 0;
      if (m_act) begin
        if (m_t < WORD_W * P) begin
          e_clk  = (m_t % P) >= LO;
          e_data = m_code[WORD_W - 1 - m_t / P];
        end
        e_le   = (m_t >= WORD_W * P + LES) && (m_t < DONE_T);
        e_done = (m_t == DONE_T);
      end
      check(ser_clk_o == e_clk, "R3 clk", ser_clk_o, e_clk);
      check(ser_data_o == e_data, "R3 data", ser_data_o, e_data);
      check(ser_le_o == e_le, "R5/R9 le", ser_le_o, e_le);
      check(done_o == e_done, "R6 done", done_o, e_done);
      check(busy_o == m_act, "R7 busy", busy_o, m_act);
      check(ser_mode_o == 1'b1, "R2 mode", ser_mode_o, 1);
    end
  end

  // behavioural slave with timing checks
  realtime t_rise, t_fall, t_dchg, t_le_rise;
  logic [WORD_W-1:0] sl_sh, sl_lat;
  int sl_bits;
  initial begin
    t_rise = -1.0e6; t_fall = -1.0e6; t_dchg = -1.0e6; t_le_rise = -1.0e6;
    sl_bits = 0; sl_sh = '0; sl_lat = '0;
  end
  always @(ser_data_o) if (rst_n) begin
    check(($realtime - t_rise) >= 20.0, "R4 data hold", int'($realtime - t_rise), 20);
    t_dchg = $realtime;
  end
  always @(posedge ser_clk_o) begin
    check(($realtime - t_dchg) >= 15.0, "R4 data setup", int'($realtime - t_dchg), 15);
    check(($realtime - t_rise) >= 70.0, "R4 clk period", int'($realtime - t_rise), 70);
    check(!ser_le_o, "R5 clk rise with le high", ser_le_o, 0);
    t_rise = $realtime;
    if (!ser_le_o) begin
      sl_sh = {sl_sh[WORD_W-2:0], ser_data_o};
      sl_bits++;
    end
  end
  always @(negedge ser_clk_o) t_fall = $realtime;
  always @(posedge ser_le_o) begin
    check(($realtime - t_fall) >= 15.0, "R5 le setup", int'($realtime - t_fall), 15);
    check(($realtime - t_le_rise) >= 630.0, "R5 le spacing", int'($realtime - t_le_rise), 630);
    check(sl_bits == WORD_W, "R3 bit count", sl_bits, WORD_W);
    t_le_rise = $realtime;
    sl_lat  = sl_sh;
    sl_bits = 0;
  end
  always @(negedge ser_le_o) if (rst_n)
    check(($realtime - t_le_rise) >= 10.0, "R5 le width", int'($realtime - t_le_rise), 10);

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic run_word(input logic [WORD_W-1:0] c);
    while (busy_o) @(negedge clk);
    start_i = 1'b1; code_i = c;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    check(sl_lat == c, "R6 latched word", sl_lat, c);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cmp_en = 0;
    rst_n = 1'b0; start_i = 1'b0; code_i = '0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !ser_clk_o && !ser_le_o && !ser_data_o, "R1 reset",
          {busy_o, done_o, ser_clk_o, ser_le_o, ser_data_o}, 0);
    check(ser_mode_o, "R2 mode in reset", ser_mode_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !ser_clk_o && !ser_le_o && !ser_data_o, "R1 after reset",
          {busy_o, ser_clk_o, ser_le_o, ser_data_o}, 0);
    cmp_en = 1;

    run_word(7'h00);
    run_word(7'h7F);
    run_word(7'h55);
    run_word(7'h2A);
    run_word(7'h01);
    run_word(7'h40);

    // R8: start mid-transfer with another code is ignored
    while (busy_o) @(negedge clk);
    start_i = 1'b1; code_i = 7'h33;
    @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    start_i = 1'b1; code_i = 7'h4C;
    @(negedge clk); start_i = 1'b0;
    wait_done();
    check(sl_lat == 7'h33, "R8 ignored start", sl_lat, 7'h33);
    repeat (10) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (busy_o) @(negedge clk);
    check(sl_lat == 7'h33, "R8 start in gap ignored", sl_lat, 7'h33);

    // R7: start held high, back-to-back words with gap enforced
    start_i = 1'b1; code_i = 7'h12;
    wait_done();
    check(sl_lat == 7'h12, "R7 first back-to-back", sl_lat, 7'h12);
    code_i = 7'h6D;
    wait_done();
    start_i = 1'b0;
    check(sl_lat == 7'h6D, "R7 second back-to-back", sl_lat, 7'h6D);
    while (busy_o) @(negedge clk);
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end
endmodule